// File: doc/BRIEF.md
# Instruction Fetch Translation Cache

This block sits in the fetch path and turns a virtual fetch address into a physical one. It holds two translations, each a pair of stored virtual page number and physical frame number. The page number is the fetch address without its 12 offset bits. The XOR of all page-number bits picks the one entry that can hold that page. Two hot pages whose page numbers differ in parity can therefore stay resident together. On a hit the physical address comes back one cycle after the fetch is accepted. On a miss the block sends one translation request, marked as an execute access, to an external page walker. It waits for the reply, returns the result and, if the walk succeeded, writes it into the selected entry.

An empty entry holds an all-ones page number instead of a valid bit. With 20-bit page numbers stored in a 32-bit field, that value can never match a real page. Software-driven maintenance can empty both entries at once, which also pulses a flush toward the instruction cache. It can also empty only the entries whose stored page falls inside a page range.

Top module: `fetch_xlat_cache`

## Requirements
- R1: A fetch hits when the entry selected by the XOR of the address bits [31:12] stores that page number. The cycle after acceptance brings `fetch_done`=1 and `fetch_hit`=1, `fetch_paddr` = {stored frame, address bits [11:0]}, and `fetch_fault`=0. No walk request is issued.
- R2: On a miss, `walk_req_valid` is high for exactly one cycle, the cycle after acceptance. `walk_req_vpn` carries the page number and `walk_req_exec` is high. `fetch_ready` stays low until the walker replies.
- R3: The cycle after `walk_rsp_valid`, `fetch_done`=1 and `fetch_hit`=0. If the reply carries no fault, `fetch_paddr` = {returned frame, offset}, and the frame is written into the selected entry, so the next fetch to that page hits.
- R4: The fault code is 0 for none, 1 for a fetch access fault and 2 for a fetch page fault. A nonzero code is passed to `fetch_fault` and leaves the entry unchanged.
- R5: After reset both entries hold the all-ones sentinel, so every page, including page 0xFFFFF, misses. `fetch_done`, `walk_req_valid` and `icache_flush` are low, and `fetch_ready` is high.
- R6: Pages of different parity occupy different entries and coexist. A page of the same parity replaces the resident one.
- R7: A one-cycle `inv_range` pulse empties every entry whose stored page lies in [`inv_lo_vpn`, `inv_hi_vpn`], both ends included. Other entries keep hitting.
- R8: A one-cycle `inv_all` pulse empties both entries and drives `icache_flush` high for exactly the following cycle.
- R9: Any invalidation while a walk is pending stops that walk's result from being installed. The result is still delivered to the fetcher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch translation request |
| fetch_vaddr | input | 32 | Virtual fetch address |
| fetch_ready | output | 1 | Block can accept a fetch |
| fetch_done | output | 1 | Result valid for one cycle |
| fetch_hit | output | 1 | Result came from a stored entry |
| fetch_paddr | output | 32 | Physical fetch address |
| fetch_fault | output | 2 | 0 none, 1 access fault, 2 page fault |
| walk_req_valid | output | 1 | Translation request pulse |
| walk_req_vpn | output | 20 | Page to translate |
| walk_req_exec | output | 1 | Request checks execute permission |
| walk_rsp_valid | input | 1 | Walker reply pulse |
| walk_rsp_ppn | input | 20 | Returned frame number |
| walk_rsp_fault | input | 2 | Returned fault code |
| inv_all | input | 1 | Empty both entries, flush instruction cache |
| inv_range | input | 1 | Empty entries inside the page range |
| inv_lo_vpn | input | 20 | Range low page, inclusive |
| inv_hi_vpn | input | 20 | Range high page, inclusive |
| icache_flush | output | 1 | Flush pulse to instruction cache |

## Verification
The assertions assume that the walker replies with a single-cycle pulse, and only while a request is pending. They also assume that at most one invalidation kind is pulsed in a cycle. The bench's walker model answers each request exactly once, two cycles after it appears. The bench raises invalidations only as single-cycle pulses, either between fetches or in the waiting cycle of a walk. Fetches are presented only while `fetch_ready` is high.

// File: rtl/fetch_xlat_cache.sv
module fetch_xlat_cache #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int TAG_W      = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_valid,
  input  logic [VA_W-1:0]            fetch_vaddr,
  output logic                       fetch_ready,
  output logic                       fetch_done,
  output logic                       fetch_hit,
  output logic [PA_W-1:0]            fetch_paddr,
  output logic [1:0]                 fetch_fault,
  output logic                       walk_req_valid,
  output logic [VA_W-PAGE_SHIFT-1:0] walk_req_vpn,
  output logic                       walk_req_exec,
  input  logic                       walk_rsp_valid,
  input  logic [PA_W-PAGE_SHIFT-1:0] walk_rsp_ppn,
  input  logic [1:0]                 walk_rsp_fault,
  input  logic                       inv_all,
  input  logic                       inv_range,
  input  logic [VA_W-PAGE_SHIFT-1:0] inv_lo_vpn,
  input  logic [VA_W-PAGE_SHIFT-1:0] inv_hi_vpn,
  output logic                       icache_flush
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int PPN_W = PA_W - PAGE_SHIFT;
  localparam logic [TAG_W-1:0] EMPTY = '1;

  logic [TAG_W-1:0]      tag_q [2];
  logic [PPN_W-1:0]      ppn_q [2];
  logic                  busy_q, stale_q, pend_idx_q;
  logic [PAGE_SHIFT-1:0] pend_off_q;

  logic [VPN_W-1:0]      lu_vpn;
  logic [PAGE_SHIFT-1:0] lu_off;
  logic                  lu_idx, lu_hit, accept, inv_any, install;

  assign lu_vpn        = fetch_vaddr[VA_W-1:PAGE_SHIFT];
  assign lu_off        = fetch_vaddr[PAGE_SHIFT-1:0];
  assign lu_idx        = ^lu_vpn;
  assign lu_hit        = tag_q[lu_idx] == TAG_W'(lu_vpn);
  assign fetch_ready   = !busy_q;
  assign accept        = fetch_valid && fetch_ready;
  assign inv_any       = inv_all || inv_range;
  assign install       = busy_q && walk_rsp_valid && walk_rsp_fault == 2'd0 && !stale_q && !inv_any;
  assign walk_req_exec = 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_entry
    logic in_range;
    assign in_range = tag_q[g] >= TAG_W'(inv_lo_vpn) && tag_q[g] <= TAG_W'(inv_hi_vpn);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g] <= EMPTY;
        ppn_q[g] <= '0;
      end else if (inv_all || (inv_range && in_range)) begin
        tag_q[g] <= EMPTY;
      end else if (install && pend_idx_q == 1'(g)) begin
        tag_q[g] <= TAG_W'(walk_req_vpn);
        ppn_q[g] <= walk_rsp_ppn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q         <= 1'b0;
      stale_q        <= 1'b0;
      pend_idx_q     <= 1'b0;
      pend_off_q     <= '0;
      walk_req_valid <= 1'b0;
      walk_req_vpn   <= '0;
      fetch_done     <= 1'b0;
      fetch_hit      <= 1'b0;
      fetch_paddr    <= '0;
      fetch_fault    <= 2'd0;
      icache_flush   <= 1'b0;
    end else begin
      icache_flush   <= inv_all;
      walk_req_valid <= 1'b0;
      fetch_done     <= 1'b0;
      if (accept) begin
        if (lu_hit) begin
          fetch_done  <= 1'b1;
          fetch_hit   <= 1'b1;
          fetch_fault <= 2'd0;
          fetch_paddr <= {ppn_q[lu_idx], lu_off};
        end else begin
          busy_q         <= 1'b1;
          stale_q        <= 1'b0;
          walk_req_valid <= 1'b1;
          walk_req_vpn   <= lu_vpn;
          pend_idx_q     <= lu_idx;
          pend_off_q     <= lu_off;
        end
      end else if (busy_q) begin
        if (inv_any) stale_q <= 1'b1;
        if (walk_rsp_valid) begin
          busy_q      <= 1'b0;
          fetch_done  <= 1'b1;
          fetch_hit   <= 1'b0;
          fetch_fault <= walk_rsp_fault;
          fetch_paddr <= (walk_rsp_fault == 2'd0) ? {walk_rsp_ppn, pend_off_q} : '0;
        end
      end
    end
  end

  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && lu_hit |=> fetch_done && fetch_hit && !walk_req_valid && fetch_fault == 2'd0); // R1
  AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lu_hit |=> walk_req_valid && walk_req_exec && !fetch_ready); // R2
  AST_WALK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |=> !walk_req_valid); // R2
  AST_RSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && walk_rsp_valid |=> fetch_done && !fetch_hit && fetch_ready); // R3
  AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && walk_rsp_valid && walk_rsp_fault != 2'd0 && !inv_any
      |=> $stable(tag_q[0]) && $stable(tag_q[1])); // R4
  AST_FULL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> icache_flush && tag_q[0] == EMPTY && tag_q[1] == EMPTY); // R8
  AST_STALE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && walk_rsp_valid && stale_q && !inv_any
      |=> $stable(tag_q[0]) && $stable(tag_q[1])); // R9
endmodule

// File: tb/fetch_xlat_cache_tb.sv
module fetch_xlat_cache_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_vaddr = '0;
  logic        fetch_ready, fetch_done, fetch_hit;
  logic [31:0] fetch_paddr;
  logic [1:0]  fetch_fault;
  logic        walk_req_valid, walk_req_exec;
  logic [19:0] walk_req_vpn;
  logic        walk_rsp_valid = 1'b0;
  logic [19:0] walk_rsp_ppn = '0;
  logic [1:0]  walk_rsp_fault = '0;
  logic        inv_all = 1'b0, inv_range = 1'b0;
  logic [19:0] inv_lo_vpn = '0, inv_hi_vpn = '0;
  logic        icache_flush;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_vaddr(fetch_vaddr), .fetch_ready(fetch_ready),
    .fetch_done(fetch_done), .fetch_hit(fetch_hit), .fetch_paddr(fetch_paddr),
    .fetch_fault(fetch_fault),
    .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn), .walk_req_exec(walk_req_exec),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_fault(walk_rsp_fault),
    .inv_all(inv_all), .inv_range(inv_range), .inv_lo_vpn(inv_lo_vpn), .inv_hi_vpn(inv_hi_vpn),
    .icache_flush(icache_flush)
  );

  function automatic logic [19:0] frame_of(input logic [19:0] vpn);
    return vpn ^ 20'h5A5A5;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] va, input logic [1:0] flt, input logic exp_hit,
                          input bit inv_mid, input string req);
    logic [19:0] vpn;
    vpn = va[31:12];
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_vaddr = va;
    @(negedge clk);
    fetch_valid = 1'b0;
    if (exp_hit) begin
      chk(req, "hit done", 64'(fetch_done), 64'd1);
      chk(req, "hit flag", 64'(fetch_hit), 64'd1);
      chk(req, "no walk on hit", 64'(walk_req_valid), 64'd0);
      chk(req, "hit paddr", 64'(fetch_paddr), 64'({frame_of(vpn), va[11:0]}));
      chk(req, "hit fault", 64'(fetch_fault), 64'd0);
    end else begin
      chk(req, "walk issued", 64'(walk_req_valid), 64'd1);
      chk("R2", "walk vpn", 64'(walk_req_vpn), 64'(vpn));
      chk("R2", "walk exec", 64'(walk_req_exec), 64'd1);
      chk("R2", "ready low while waiting", 64'(fetch_ready), 64'd0);
      if (inv_mid) inv_all = 1'b1;
      @(negedge clk);
      inv_all = 1'b0;
      chk("R2", "walk pulse single", 64'(walk_req_valid), 64'd0);
      walk_rsp_valid = 1'b1;
      walk_rsp_ppn   = frame_of(vpn);
      walk_rsp_fault = flt;
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      chk(req, "miss done", 64'(fetch_done), 64'd1);
      chk(req, "miss flag", 64'(fetch_hit), 64'd0);
      chk(req, "miss fault", 64'(fetch_fault), 64'(flt));
      if (flt == 2'd0) chk(req, "miss paddr", 64'(fetch_paddr), 64'({frame_of(vpn), va[11:0]}));
    end
  endtask

  task automatic pulse_range(input logic [19:0] lo, input logic [19:0] hi);
    @(negedge clk);
    inv_range = 1'b1; inv_lo_vpn = lo; inv_hi_vpn = hi;
    @(negedge clk);
    inv_range = 1'b0;
  endtask

  // {vaddr, walker fault, expected hit}; fault 1 access, 2 page
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {32'h0000_1004, 2'd0, 1'b0},  // R6 parity 1 entry
    {32'h0000_1FF8, 2'd0, 1'b1},  // R1
    {32'h0000_3010, 2'd0, 1'b0},  // R6 parity 0 entry
    {32'h0000_1100, 2'd0, 1'b1},  // R6 coexist
    {32'h0000_3020, 2'd0, 1'b1},
    {32'h0000_7000, 2'd0, 1'b0},  // R6 replaces page 1
    {32'h0000_1000, 2'd0, 1'b0},  // R6 page 1 evicted
    {32'h0000_5000, 2'd2, 1'b0},  // R4 page fault
    {32'h0000_3044, 2'd0, 1'b1},  // R4 entry kept
    {32'h0000_5000, 2'd1, 1'b0},  // R4 access fault, still not installed
    {32'h0000_0ABC, 2'd0, 1'b0},  // R3 install page 0
    {32'h0000_0000, 2'd0, 1'b1}   // R3
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R5", "ready", 64'(fetch_ready), 64'd1);
    chk("R5", "done", 64'(fetch_done), 64'd0);
    chk("R5", "walk", 64'(walk_req_valid), 64'd0);
    chk("R5", "flush", 64'(icache_flush), 64'd0);
    do_fetch(32'hFFFF_F000, 2'd0, 1'b0, 1'b0, "R5");

    for (int i = 0; i < NV; i++) begin
      string r;
      r = VEC[i][0] ? "R1" : (VEC[i][2:1] != 2'd0 ? "R4" : "R3");
      do_fetch(VEC[i][34:3], VEC[i][2:1], VEC[i][0], 1'b0, r);
    end

    // entries now: page 0 (parity 0), page 1 (parity 1)
    pulse_range(20'd2, 20'h10);
    do_fetch(32'h0000_0004, 2'd0, 1'b1, 1'b0, "R7");
    do_fetch(32'h0000_1004, 2'd0, 1'b1, 1'b0, "R7");
    pulse_range(20'd1, 20'd1);
    do_fetch(32'h0000_0008, 2'd0, 1'b1, 1'b0, "R7");
    do_fetch(32'h0000_1008, 2'd0, 1'b0, 1'b0, "R7");
    pulse_range(20'd0, 20'd0);
    do_fetch(32'h0000_0010, 2'd0, 1'b0, 1'b0, "R7");

    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    chk("R8", "flush pulse", 64'(icache_flush), 64'd1);
    @(negedge clk);
    chk("R8", "flush ends", 64'(icache_flush), 64'd0);
    do_fetch(32'h0000_0010, 2'd0, 1'b0, 1'b0, "R8");
    do_fetch(32'h0000_1010, 2'd0, 1'b0, 1'b0, "R8");

    do_fetch(32'h0000_7123, 2'd0, 1'b0, 1'b1, "R9");
    do_fetch(32'h0000_7124, 2'd0, 1'b0, 1'b0, "R9");
    do_fetch(32'h0000_7128, 2'd0, 1'b1, 1'b0, "R3");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule